// File: doc/BRIEF.md
# Two-Road Intersection Signal Sequencer

This block drives the signal heads of a four-way crossing where the east-west road has priority (the main road) and the north-south road is secondary. Each road has four lamps: red, yellow, green and a protected left-turn arrow. A prescaler turns the system clock into a one-second tick. On each tick a phase machine steps through a fixed eight-phase cycle. The main road runs green, yellow, left-turn and yellow while the secondary road holds red. The secondary road then runs its own four phases while the main road holds red.

Two countdown registers hold the seconds left for each road as two packed BCD digits. A road that is moving shows the time left in its current phase. A road held at red shows the time left until its red ends, and that count spans all four phases of the other road. The values go straight to a display driver outside this block.

Top module: `xing_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters main green with the main countdown at 0x45 and the secondary countdown at 0x70. The prescaler restarts, so the first tick comes TICK_DIV clocks after reset is released.
- R2: The main road shows green for 45 s, then yellow for 5 s, then left-turn for 15 s, then yellow for 5 s. The secondary road shows red for that whole time.
- R3: The secondary road then shows green for 40 s, then yellow for 5 s, then left-turn for 10 s, then yellow for 5 s. The main road shows red for that whole time.
- R4: A road held at red counts its red time down: the main road from 60 (the secondary phases summed) and the secondary road from 70 (the main phases summed). The count runs through every phase of the other road without reloading.
- R5: Countdowns are packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. Each drops by one per tick and shows 1 during the last second of its period. A moving road's countdown reloads with the next phase's duration when the phase changes.
- R6: Lamp buses are active-low, with bit 0 red, bit 1 yellow, bit 2 green and bit 3 left-turn. Exactly one bit of each road's bus is low at any time.
- R7: A tick occurs once every TICK_DIV clocks. Lamps and countdowns change only on the clock edge that ends a tick cycle.
- R8: After 130 s the cycle wraps to main green with the countdowns reloaded to 0x45 and 0x70, and it then repeats unchanged.
- R9: A reset asserted in the middle of the cycle returns the block to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_lamp_n | output | 4 | Main road lamps, active-low: bit 0 red, bit 1 yellow, bit 2 green, bit 3 left |
| side_lamp_n | output | 4 | Secondary road lamps, same encoding as the main road |
| main_count | output | 8 | Main road seconds remaining, packed BCD |
| side_count | output | 8 | Secondary road seconds remaining, packed BCD |

## Verification
The hardest behaviour to reach is the handover between roads. At that edge one countdown must reload while the other keeps counting through a boundary, for example main red going from 21 to 20 as the secondary road leaves green. A second hard case is the wrap from the 130th second back to main green. The bench shortens the tick to a few clocks through TICK_DIV, then runs two full cycles. It compares both lamp buses and both countdowns on every clock against the times expected from the phase durations alone. It ends with a reset asserted in the middle of a phase.

// File: rtl/xing_pkg.sv
package xing_pkg;

    localparam int SEC_W = 7;

    typedef enum logic [2:0] {
        PH_M_GO    = 3'd0,
        PH_M_AMB1  = 3'd1,
        PH_M_TURN  = 3'd2,
        PH_M_AMB2  = 3'd3,
        PH_S_GO    = 3'd4,
        PH_S_AMB1  = 3'd5,
        PH_S_TURN  = 3'd6,
        PH_S_AMB2  = 3'd7
    } phase_e;

    // active-low lamp codes: bit0 red, bit1 yellow, bit2 green, bit3 left
    localparam logic [3:0] LAMP_RED   = 4'b1110;
    localparam logic [3:0] LAMP_AMBER = 4'b1101;
    localparam logic [3:0] LAMP_GREEN = 4'b1011;
    localparam logic [3:0] LAMP_LEFT  = 4'b0111;

    function automatic logic is_main(input phase_e p);
        return (p[2] == 1'b0);
    endfunction

    function automatic logic [7:0] to_bcd(input logic [SEC_W-1:0] v);
        logic [SEC_W-1:0] tens;
        logic [SEC_W-1:0] ones;
        tens = v / SEC_W'(10);
        ones = v % SEC_W'(10);
        return {tens[3:0], ones[3:0]};
    endfunction

endpackage

// File: rtl/xing_prescaler.sv
module xing_prescaler #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_s;

    pre_s st_d, st_q;

    assign tick_o = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (TICK_DIV == 1 || !tick_o));

endmodule

// File: rtl/xing_phase_fsm.sv
module xing_phase_fsm
    import xing_pkg::*;
#(
    parameter int M_GO_S   = 45,
    parameter int M_AMB_S  = 5,
    parameter int M_TURN_S = 15,
    parameter int S_GO_S   = 40,
    parameter int S_AMB_S  = 5,
    parameter int S_TURN_S = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    output phase_e           phase_o,
    output logic [SEC_W-1:0] remain_o,
    output logic             advance_o,
    output phase_e           next_phase_o,
    output logic [SEC_W-1:0] next_dur_o
);
    typedef struct packed {
        phase_e           phase;
        logic [SEC_W-1:0] remain;
    } fsm_s;

    fsm_s st_d, st_q;

    function automatic logic [SEC_W-1:0] dur_of(input phase_e p);
        case (p)
            PH_M_GO:              return SEC_W'(M_GO_S);
            PH_M_TURN:            return SEC_W'(M_TURN_S);
            PH_M_AMB1, PH_M_AMB2: return SEC_W'(M_AMB_S);
            PH_S_GO:              return SEC_W'(S_GO_S);
            PH_S_TURN:            return SEC_W'(S_TURN_S);
            default:              return SEC_W'(S_AMB_S);
        endcase
    endfunction

    assign next_phase_o = phase_e'(st_q.phase + 3'd1);
    assign next_dur_o   = dur_of(next_phase_o);
    assign advance_o    = tick_i && (st_q.remain == SEC_W'(1));
    assign phase_o      = st_q.phase;
    assign remain_o     = st_q.remain;

    always_comb begin
        st_d = st_q;
        if (advance_o) begin
            st_d.phase  = next_phase_o;
            st_d.remain = next_dur_o;
        end else if (tick_i) begin
            st_d.remain = st_q.remain - SEC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase  <= PH_M_GO;
            st_q.remain <= SEC_W'(M_GO_S);
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(phase_o) && $stable(remain_o));

    // R5
    remain_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        remain_o != '0);

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        advance_o |=> phase_o != $past(phase_o));

endmodule

// File: rtl/xing_bcd_down.sv
module xing_bcd_down #(
    parameter logic [7:0] RST_VAL = 8'h45
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    output logic [7:0] value_o
);
    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd_s;

    bcd_s st_d, st_q;

    assign value_o = st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d = load_val_i;
        end else if (tick_i) begin
            if (st_q.ones == 4'd0) begin
                st_d.ones = 4'd9;
                st_d.tens = st_q.tens - 4'd1;
            end else begin
                st_d.ones = st_q.ones - 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_VAL;
        else     st_q <= st_d;
    end

    // R5
    bcd_digit_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.ones <= 4'd9 && st_q.tens <= 4'd9 && st_q != '0);

endmodule

// File: rtl/xing_sequencer.sv
module xing_sequencer
    import xing_pkg::*;
#(
    parameter int TICK_DIV = 50_000_000,
    parameter int M_GO_S   = 45,
    parameter int M_AMB_S  = 5,
    parameter int M_TURN_S = 15,
    parameter int S_GO_S   = 40,
    parameter int S_AMB_S  = 5,
    parameter int S_TURN_S = 10
) (
    input  logic       clk,
    input  logic       rst,
    output logic [3:0] main_lamp_n,
    output logic [3:0] side_lamp_n,
    output logic [7:0] main_count,
    output logic [7:0] side_count
);
    localparam int M_TOTAL = M_GO_S + M_TURN_S + 2 * M_AMB_S;
    localparam int S_TOTAL = S_GO_S + S_TURN_S + 2 * S_AMB_S;
    localparam logic [7:0] M_RST_BCD = 8'((M_GO_S / 10) * 16 + (M_GO_S % 10));
    localparam logic [7:0] S_RST_BCD = 8'((M_TOTAL / 10) * 16 + (M_TOTAL % 10));

    logic             tick;
    phase_e           phase;
    phase_e           next_phase;
    logic [SEC_W-1:0] remain;
    logic [SEC_W-1:0] next_dur;
    logic             advance;
    logic             main_load, side_load;
    logic [7:0]       main_load_val, side_load_val;

    xing_prescaler #(.TICK_DIV(TICK_DIV)) i_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    xing_phase_fsm #(
        .M_GO_S(M_GO_S), .M_AMB_S(M_AMB_S), .M_TURN_S(M_TURN_S),
        .S_GO_S(S_GO_S), .S_AMB_S(S_AMB_S), .S_TURN_S(S_TURN_S)
    ) i_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .phase_o      (phase),
        .remain_o     (remain),
        .advance_o    (advance),
        .next_phase_o (next_phase),
        .next_dur_o   (next_dur)
    );

    // main reloads on entering its own phases or the start of its red span
    always_comb begin
        main_load     = advance && (is_main(next_phase) || next_phase == PH_S_GO);
        main_load_val = is_main(next_phase) ? to_bcd(next_dur) : to_bcd(SEC_W'(S_TOTAL));
        side_load     = advance && (!is_main(next_phase) || next_phase == PH_M_GO);
        side_load_val = !is_main(next_phase) ? to_bcd(next_dur) : to_bcd(SEC_W'(M_TOTAL));
    end

    xing_bcd_down #(.RST_VAL(M_RST_BCD)) i_main_cd (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .load_i     (main_load),
        .load_val_i (main_load_val),
        .value_o    (main_count)
    );

    xing_bcd_down #(.RST_VAL(S_RST_BCD)) i_side_cd (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .load_i     (side_load),
        .load_val_i (side_load_val),
        .value_o    (side_count)
    );

    always_comb begin
        main_lamp_n = LAMP_RED;
        side_lamp_n = LAMP_RED;
        case (phase)
            PH_M_GO:              main_lamp_n = LAMP_GREEN;
            PH_M_AMB1, PH_M_AMB2: main_lamp_n = LAMP_AMBER;
            PH_M_TURN:            main_lamp_n = LAMP_LEFT;
            PH_S_GO:              side_lamp_n = LAMP_GREEN;
            PH_S_AMB1, PH_S_AMB2: side_lamp_n = LAMP_AMBER;
            default:              side_lamp_n = LAMP_LEFT;
        endcase
    end

    // R6
    lamp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~main_lamp_n) == 1 && $countones(~side_lamp_n) == 1);

    // R4
    main_track_chk: assert property (@(posedge clk) disable iff (rst)
        is_main(phase) |-> main_count == to_bcd(remain));

    // R4
    side_track_chk: assert property (@(posedge clk) disable iff (rst)
        !is_main(phase) |-> side_count == to_bcd(remain));

endmodule

// File: tb/test_xing_sequencer.sv
module test_xing_sequencer;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] main_lamp_n, side_lamp_n;
    logic [7:0] main_count, side_count;

    int n_checks = 0;
    int n_fail   = 0;
    int sec_t    = 0;
    int sub      = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    xing_sequencer #(.TICK_DIV(DIV)) i_xing_sequencer (
        .clk         (clk),
        .rst         (rst),
        .main_lamp_n (main_lamp_n),
        .side_lamp_n (side_lamp_n),
        .main_count  (main_count),
        .side_count  (side_count)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%h expected=%h", tag, sec_t, act, exp);
        end
    endtask

    // expected outputs from second-in-cycle t, derived from phase durations
    task automatic check_all();
        logic [3:0] ml, sl;
        int mc, sc;
        int t = sec_t;
        ml = 4'b1110; sl = 4'b1110;
        if      (t < 45)  begin ml = 4'b1011; mc = 45 - t;  sc = 70 - t; end
        else if (t < 50)  begin ml = 4'b1101; mc = 50 - t;  sc = 70 - t; end
        else if (t < 65)  begin ml = 4'b0111; mc = 65 - t;  sc = 70 - t; end
        else if (t < 70)  begin ml = 4'b1101; mc = 70 - t;  sc = 70 - t; end
        else if (t < 110) begin sl = 4'b1011; mc = 130 - t; sc = 110 - t; end
        else if (t < 115) begin sl = 4'b1101; mc = 130 - t; sc = 115 - t; end
        else if (t < 125) begin sl = 4'b0111; mc = 130 - t; sc = 125 - t; end
        else              begin sl = 4'b1101; mc = 130 - t; sc = 130 - t; end
        check8("R2/R6 main lamps", {4'b0, main_lamp_n}, {4'b0, ml});
        check8("R3/R6 side lamps", {4'b0, side_lamp_n}, {4'b0, sl});
        check8("R4/R5/R7 main count", main_count, bcd(mc));
        check8("R4/R5/R7 side count", side_count, bcd(sc));
    endtask

    task automatic step_clock();
        @(posedge clk);
        sub++;
        if (sub == DIV) begin
            sub = 0;
            sec_t = (sec_t + 1) % 130;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sec_t = 0;
        sub = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check8("R1 main lamps", {4'b0, main_lamp_n}, 8'h0b);
        check8("R1 side lamps", {4'b0, side_lamp_n}, 8'h0e);
        check8("R1 main count", main_count, 8'h45);
        check8("R1 side count", side_count, 8'h70);
    endtask

    task automatic t_full_cycle();
        for (int i = 0; i < 130 * DIV; i++) step_clock();
    endtask

    task automatic t_wrap();
        // R8: first edge of second cycle is main green 45/70 again
        check8("R8 wrap main count", main_count, 8'h45);
        check8("R8 wrap side count", side_count, 8'h70);
        check8("R8 wrap main lamps", {4'b0, main_lamp_n}, 8'h0b);
        for (int i = 0; i < 130 * DIV; i++) step_clock();
    endtask

    task automatic t_mid_reset();
        for (int i = 0; i < 83 * DIV + 2; i++) step_clock();
        check8("R9 pre-reset side lamps", {4'b0, side_lamp_n}, 8'h0b);
        do_reset();
        check8("R9 main count", main_count, 8'h45);
        check8("R9 side count", side_count, 8'h70);
        check8("R9 main lamps", {4'b0, main_lamp_n}, 8'h0b);
        check8("R9 side lamps", {4'b0, side_lamp_n}, 8'h0e);
        for (int i = 0; i < 3 * DIV; i++) step_clock();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        t_reset_state();
        t_full_cycle();
        t_wrap();
        t_mid_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule